// File: doc/BRIEF.md
# Bit Scatter/Gather Unit

This block moves the bits of a data word under the control of a selection mask, one mask bit per clock cycle. In scatter mode (deposit), the lowest bits of the source word are placed, in order, at the positions where the mask holds a 1. In gather mode (extract), the source bits that sit under the 1 bits of the mask are packed, in order, into the low end of the result. Every result bit that the operation does not write is 0.

A caller presents the operands together with a one-cycle `start` while the unit is idle. The unit captures the operands on that edge. On each following cycle it finds the lowest remaining 1 in its copy of the mask, moves one bit, and clears that mask bit. When the copy of the mask is empty, it raises `valid` for one cycle. A run therefore takes a number of cycles set by the mask's population count, not by the word width. The result stays on `result` until the next accepted start.

Top module: `pdx_unit`

## Requirements
- R1: With `op` = 0 (deposit), source bit k (k counted from bit 0) is written to the bit position of the k-th lowest 1 in the mask.
- R2: With `op` = 1 (extract), the source bit at the position of the k-th lowest 1 in the mask is written to result bit k.
- R3: Result bits not written by the operation are 0, so an all-zero mask gives a zero result in both modes.
- R4: `valid` is a one-cycle pulse that rises on the (P+1)-th rising edge after the edge that accepted `start`, where P is the population count of the mask. With a zero mask, this is the first edge after acceptance.
- R5: `op`, `src` and `mask` are captured on the accepting edge, and later changes to them do not affect the running operation.
- R6: `start` is accepted only when the unit is idle, and a `start` seen while an operation is running has no effect.
- R7: After `valid`, `result` holds its value until the next accepted `start`.
- R8: Synchronous active-high `rst` drives `valid` to 0 and `result` to 0.
- R9: Each working cycle removes exactly one bit, the lowest remaining 1, from the unit's copy of the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation, sampled while idle |
| op | input | 1 | 0 = deposit (scatter), 1 = extract (gather) |
| src | input | W | Source data word |
| mask | input | W | Selection mask |
| result | output | W | Operation result, held after completion |
| valid | output | 1 | One-cycle completion pulse |

## Verification
The latency of a run depends on the data: `valid` is due P+1 edges after the accepting edge, where P is the mask's population count. The bench computes P for every stimulus. It counts edges from acceptance, sampling one time unit after each rising edge, and compares the count with P+1 at the first edge where `valid` is high. It reads `result` at that same sample and compares it with a value from an arithmetic model. It reads `result` again two edges later, while `valid` is low, to check that the value is held.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    typedef enum logic {
        OP_DEPOSIT = 1'b0,
        OP_EXTRACT = 1'b1
    } pdx_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pdx_state_e;

    function automatic int unsigned idx_bits(input int unsigned width);
        return (width <= 1) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/pdx_lowbit.sv
module pdx_lowbit #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 5
) (
    input  logic [W-1:0]  bits,
    output logic [W-1:0]  rest,
    output logic [IW-1:0] pos
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] iso;

    // isolate lowest set bit, then clear it (value AND value-1)
    assign iso  = bits & (~bits + ONE);
    assign rest = bits & (bits - ONE);

    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (iso[i]) pos = pos | IW'(i);
        end
    end
endmodule

// File: rtl/pdx_step.sv
module pdx_step
    import pdx_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 5
) (
    input  pdx_op_e       op,
    input  logic [W-1:0]  src,
    input  logic [W-1:0]  acc,
    input  logic [IW-1:0] mpos,
    input  logic [IW-1:0] kpos,
    output logic [W-1:0]  nxt
);
    always_comb begin
        nxt = acc;
        if (op == OP_DEPOSIT) begin
            nxt[mpos] = src[kpos];
        end else begin
            nxt[kpos] = src[mpos];
        end
    end
endmodule

// File: rtl/pdx_unit.sv
module pdx_unit
    import pdx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] result,
    output logic         valid
);
    localparam int unsigned IW = idx_bits(W);
    localparam logic [IW-1:0] K_ONE = {{(IW-1){1'b0}}, 1'b1};

    pdx_state_e    state_q;
    pdx_op_e       op_q;
    logic [W-1:0]  src_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  res_q;
    logic [IW-1:0] k_q;
    logic          valid_q;

    logic [W-1:0]  rem_next;
    logic [IW-1:0] low_pos;
    logic [W-1:0]  res_next;
    logic          accept;

    assign accept = start && (state_q == ST_IDLE);

    pdx_lowbit #(.W(W), .IW(IW)) u_low (
        .bits (rem_q),
        .rest (rem_next),
        .pos  (low_pos)
    );

    pdx_step #(.W(W), .IW(IW)) u_step (
        .op   (op_q),
        .src  (src_q),
        .acc  (res_q),
        .mpos (low_pos),
        .kpos (k_q),
        .nxt  (res_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_DEPOSIT;
            src_q   <= '0;
            rem_q   <= '0;
            res_q   <= '0;
            k_q     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= pdx_op_e'(op);
                        src_q   <= src;
                        rem_q   <= mask;
                        res_q   <= '0;
                        k_q     <= '0;
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    if (rem_q == '0) begin
                        valid_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        res_q <= res_next;
                        rem_q <= rem_next;
                        k_q   <= k_q + K_ONE;
                    end
                end
            endcase
        end
    end

    assign result = res_q;
    assign valid  = valid_q;

    AST_STEP_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && rem_q != '0) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1)); // R9
    AST_EMPTY_FINISHES: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && rem_q == '0) |=> valid); // R4
    AST_ZERO_MASK_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept && mask == '0) |=> ##1 valid); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> $stable(result)); // R7
    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> ($stable(src_q) && $stable(op_q))); // R5
    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && rem_q != '0 && start) |=> (state_q == ST_RUN)); // R6
endmodule

// File: tb/pdx_unit_test.sv
module pdx_unit_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] mask = '0;
    logic [W-1:0] result;
    logic         valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pdx_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src(src), .mask(mask), .result(result), .valid(valid)
    );

    function automatic logic [W-1:0] model(input logic o, input logic [W-1:0] s,
                                           input logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                if (!o) r[i] = s[k];
                else    r[k] = s[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic int popc(input logic [W-1:0] m);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(m[i]);
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic o, input logic [W-1:0] s, input logic [W-1:0] m,
                       input bit busy_start);
        logic [W-1:0] exp;
        int cyc;
        string rq;
        exp = model(o, s, m);
        rq  = (m == '0) ? "R3" : (o ? "R2" : "R1");
        @(negedge clk);
        start = 1'b1; op = o; src = s; mask = m;
        @(posedge clk);
        #1;
        // R5: scramble operands after capture; R6: optionally keep start high
        start = busy_start; op = ~o; src = ~s; mask = ~m;
        cyc = 0;
        do begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc == 2) start = 1'b0;
        end while (!valid && cyc < 3 * W);
        // R4, R9: one working cycle per mask bit plus one
        check(cyc == popc(m) + 1, "R4", cyc, popc(m) + 1);
        check(result == exp, busy_start ? "R6" : rq, int'(result), int'(exp));
        start = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(!valid && result == exp, "R7", int'(result), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(valid == 1'b0 && result == '0, "R8", int'(result), 0);
        // R1 R2 R3 sweep over every mask with three source patterns
        for (int m = 0; m < 256; m++) begin
            for (int o = 0; o < 2; o++) begin
                run(o[0], 8'hFF, m[7:0], 1'b0);
                run(o[0], 8'hA5, m[7:0], 1'b0);
                run(o[0], 8'((m * 37 + 11) & 255), m[7:0], 1'b0);
            end
        end
        // R6: start held high while busy
        run(1'b0, 8'hFF, 8'hF0, 1'b1);
        run(1'b1, 8'h5A, 8'hCC, 1'b1);
        // R8: reset after a finished run clears the result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(valid == 1'b0 && result == '0, "R8", int'(result), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule